// File: doc/BRIEF.md
# Polarity-Alternating PWM Generator

This block produces one fast-PWM output from a free-running up-counter and flips the output's polarity after a programmable number of PWM periods. The counter climbs from zero to a programmable top value and wraps, so each period lasts top + 1 clocks. The output is active while the count does not exceed a programmable compare value. Every change to top, compare, polarity, enable or mode is staged, and it reaches the waveform only at a period boundary or at a commutation event. As a result, an inversion never cuts a pulse short.

A commutation event happens when the internal repeat counter runs out, which inverts the waveform, or when software pulses the commutation strobe. The strobe only transfers the staged control bits and restarts the repeat count. A second mode suits fixed 50% waveforms. The period is programmed to half its length, and each period is then entirely active or entirely inactive, alternating. The inversion comes from skipping one alternation at each repeat expiry. A debug flag toggles at every inversion, and an update pulse marks the last clock of each period.

Top module: `pwm_flip_gen`

## Requirements
- R1: A synchronous reset sets the counter to 0, top to 23, compare to 11, the inversion interval to 8 periods, the control to enabled, non-inverted and normal mode, and the inversion state and flip_dbg to 0. The first clock after reset drives pwm_out high and upd_pulse low.
- R2: The counter steps by one on every clock and wraps from top to 0. upd_pulse is high exactly during the clock in which the count equals top.
- R3: In normal mode the raw level is 1 when count <= compare and 0 otherwise. A compare value above top therefore gives a constant active level, and a compare of 0 gives a one-clock pulse per period. pwm_out = enable AND (raw XOR invert XOR inversion state).
- R4: Register writes use wr_sel: 0 selects top, 1 compare, 2 interval, 3 control. A top or compare write, made in any clock of a period including its last, takes effect from the first clock of the next period and never inside the current one.
- R5: When the period ends with the repeat count at 1, an expiry occurs. In normal mode the inversion state toggles, so the waveform inverts every N periods, and flip_dbg toggles at every expiry. A written interval of 0 is treated as 1.
- R6: The repeat count reloads from the stored interval on every commutation, so a new interval (wr_data[7:0]) governs only the intervals that start after a later reload.
- R7: Control writes (bit 0 invert, bit 1 enable, bit 2 alternating mode) are staged. They reach the output only on a commutation event, which is either an expiry or com_strobe. A write in the same clock as the event is applied by it.
- R8: com_strobe reloads the repeat count and applies the staged control, but it does not itself invert the waveform or toggle flip_dbg.
- R9: In alternating mode the raw level is constant for the whole period and toggles at each period end, except at an expiry, where it holds. Expiry then leaves the inversion state unchanged.
- R10: With enable at 0, pwm_out stays low while the counter, repeat count and inversion continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 top, 1 compare, 2 interval, 3 control |
| wr_data | input | CW | Write data |
| com_strobe | input | 1 | Software commutation request |
| pwm_out | output | 1 | PWM output |
| upd_pulse | output | 1 | High in the last clock of each period |
| flip_dbg | output | 1 | Toggles at every repeat expiry |

## Verification
The assertions check, on every clock, the properties that hold at all times. The counter advances by one except at a wrap, and every update pulse is followed by a zero count. Active top and compare move only at a period end, the active control moves only on a commutation, and flip_dbg changes only at an expiry. The bench's scenarios are needed for the timing that depends on what was written. These include shadow writes landing in the right period, interval changes waiting for a reload, the strobe that transfers control without inverting, the out-of-range and zero compare values, and the alternating mode's skipped toggle. A behavioural model covers all of these on every clock.

// File: rtl/pwm_flip_gen.sv
module pwm_flip_gen #(
  parameter int CW      = 16,
  parameter int RW      = 8,
  parameter int DEF_TOP = 23,
  parameter int DEF_CMP = 11,
  parameter int DEF_REP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          com_strobe,
  output logic          pwm_out,
  output logic          upd_pulse,
  output logic          flip_dbg
);
  localparam logic [1:0]    SEL_TOP = 2'd0;
  localparam logic [1:0]    SEL_CMP = 2'd1;
  localparam logic [1:0]    SEL_REP = 2'd2;
  localparam logic [1:0]    SEL_CTL = 2'd3;
  localparam logic [CW-1:0] TOP0 = CW'(DEF_TOP);
  localparam logic [CW-1:0] CMP0 = CW'(DEF_CMP);
  localparam logic [RW-1:0] REP0 = RW'(DEF_REP);
  localparam logic [RW-1:0] ONE  = RW'(1);
  localparam logic [2:0]    CTL0 = 3'b010;

  logic [CW-1:0] cnt, top_sh, top_act, cmp_sh, cmp_act;
  logic [RW-1:0] rep_cfg, rep_cnt;
  logic [2:0]    ctl_pre, ctl_act;
  logic          flip, ph, dbg;

  wire wr_top = wr_en && wr_sel == SEL_TOP;
  wire wr_cmp = wr_en && wr_sel == SEL_CMP;
  wire wr_rep = wr_en && wr_sel == SEL_REP;
  wire wr_ctl = wr_en && wr_sel == SEL_CTL;

  wire wrap   = cnt == top_act;
  wire expire = wrap && rep_cnt == ONE;
  wire com    = expire || com_strobe;

  wire [CW-1:0] top_nxt = wr_top ? wr_data : top_sh;
  wire [CW-1:0] cmp_nxt = wr_cmp ? wr_data : cmp_sh;
  wire [2:0]    ctl_nxt = wr_ctl ? wr_data[2:0] : ctl_pre;
  wire [RW-1:0] rep_wr  = (wr_data[RW-1:0] == '0) ? ONE : wr_data[RW-1:0];

  wire raw = ctl_act[2] ? ph : (cnt <= cmp_act);

  assign pwm_out   = ctl_act[1] & (raw ^ ctl_act[0] ^ flip);
  assign upd_pulse = wrap;
  assign flip_dbg  = dbg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      top_sh  <= TOP0;
      top_act <= TOP0;
      cmp_sh  <= CMP0;
      cmp_act <= CMP0;
      rep_cfg <= REP0;
      rep_cnt <= REP0;
      ctl_pre <= CTL0;
      ctl_act <= CTL0;
      flip    <= 1'b0;
      ph      <= 1'b1;
      dbg     <= 1'b0;
    end else begin
      top_sh  <= top_nxt;
      cmp_sh  <= cmp_nxt;
      ctl_pre <= ctl_nxt;
      if (wr_rep) rep_cfg <= rep_wr;
      if (wrap) begin
        cnt     <= '0;
        top_act <= top_nxt;
        cmp_act <= cmp_nxt;
        if (!expire) ph <= ~ph;
      end else begin
        cnt <= cnt + CW'(1);
      end
      if (com)       rep_cnt <= rep_cfg;
      else if (wrap) rep_cnt <= rep_cnt - ONE;
      if (com) ctl_act <= ctl_nxt;
      if (expire) begin
        dbg <= ~dbg;
        if (!ctl_act[2]) flip <= ~flip;
      end
    end
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt == $past(cnt) + CW'(1));
  p_upd_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> cnt == '0);
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |=> $stable(cmp_act) && $stable(top_act));
  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(expire || com_strobe) |=> $stable(ctl_act));
  p_dbg_only_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    !expire |=> $stable(flip_dbg));
  p_rep_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    rep_cnt != '0);
endmodule

// File: tb/pwm_flip_gen_tb.sv
module pwm_flip_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        com_strobe = 1'b0;
  logic        pwm_out, upd_pulse, flip_dbg;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";

  int m_cnt, m_top, m_topsh, m_cmp, m_cmpsh, m_rep, m_repcnt;
  int m_pre, m_act, m_flip, m_ph, m_dbg;

  pwm_flip_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .com_strobe(com_strobe), .pwm_out(pwm_out), .upd_pulse(upd_pulse),
    .flip_dbg(flip_dbg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int wrp, exp_e, old_act, nxt_pre, nts, ncs, reload;
    if (rst) begin
      m_cnt = 0; m_top = 23; m_topsh = 23; m_cmp = 11; m_cmpsh = 11;
      m_rep = 8; m_repcnt = 8; m_pre = 2; m_act = 2;
      m_flip = 0; m_ph = 1; m_dbg = 0;
    end else begin
      wrp     = (m_cnt == m_top) ? 1 : 0;
      exp_e   = (wrp == 1 && m_repcnt == 1) ? 1 : 0;
      old_act = m_act;
      reload  = m_rep;
      nts     = (wr_en && wr_sel == 2'd0) ? int'(wr_data) : m_topsh;
      ncs     = (wr_en && wr_sel == 2'd1) ? int'(wr_data) : m_cmpsh;
      nxt_pre = (wr_en && wr_sel == 2'd3) ? int'(wr_data[2:0]) : m_pre;
      m_topsh = nts;
      m_cmpsh = ncs;
      m_pre   = nxt_pre;
      if (wr_en && wr_sel == 2'd2) m_rep = (wr_data[7:0] == 8'd0) ? 1 : int'(wr_data[7:0]);
      if (wrp == 1) begin
        m_cnt = 0; m_top = nts; m_cmp = ncs;
        if (exp_e == 0) m_ph = 1 - m_ph;
      end else m_cnt = m_cnt + 1;
      if (exp_e == 1 || com_strobe) m_repcnt = reload;
      else if (wrp == 1) m_repcnt = m_repcnt - 1;
      if (exp_e == 1 || com_strobe) m_act = nxt_pre;
      if (exp_e == 1) begin
        m_dbg = 1 - m_dbg;
        if ((old_act & 4) == 0) m_flip = 1 - m_flip;
      end
    end
  end

  function automatic int exp_pwm();
    int raw;
    if ((m_act & 4) != 0) raw = m_ph;
    else raw = (m_cnt <= m_cmp) ? 1 : 0;
    if ((m_act & 2) == 0) return 0;
    return raw ^ (m_act & 1) ^ m_flip;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      check(pwm_out == exp_pwm(), cur_req, "pwm_out", pwm_out, exp_pwm());
      check(upd_pulse == (m_cnt == m_top), "R2", "upd_pulse", upd_pulse, int'(m_cnt == m_top));
      check(flip_dbg == m_dbg, cur_req, "flip_dbg", flip_dbg, m_dbg);
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    com_strobe = 1'b1;
    @(negedge clk);
    com_strobe = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b1, "R1", "pwm_out after reset", pwm_out, 1);
    check(flip_dbg == 1'b0, "R1", "flip_dbg after reset", flip_dbg, 0);
    check(upd_pulse == 1'b0, "R1", "upd_pulse after reset", upd_pulse, 0);
    running = 1'b1;
    cur_req = "R5";
    repeat (24 * 18) @(negedge clk);
    cur_req = "R4";
    wait_cnt(5);  wr(1, 5);
    repeat (30) @(negedge clk);
    wait_cnt(23); wr(0, 9);
    wait_cnt(9);  wr(1, 2);
    repeat (40) @(negedge clk);
    cur_req = "R3";
    wr(1, 30);
    repeat (25) @(negedge clk);
    wr(1, 0);
    repeat (25) @(negedge clk);
    wr(0, 23); wr(1, 11);
    cur_req = "R6";
    wait_cnt(4); wr(2, 3);
    repeat (24 * 14) @(negedge clk);
    cur_req = "R5";
    wr(2, 0);
    repeat (24 * 6) @(negedge clk);
    wr(2, 8);
    cur_req = "R7";
    wr(3, 3);
    repeat (24 * 10) @(negedge clk);
    wr(3, 2);
    repeat (50) @(negedge clk);
    cur_req = "R8";
    wait_cnt(7); wr(3, 3); strobe();
    repeat (60) @(negedge clk);
    cur_req = "R10";
    wr(3, 1); strobe();
    repeat (24 * 9) @(negedge clk);
    cur_req = "R9";
    wr(0, 11); wr(2, 4);
    wait_cnt(11); wr(3, 6);
    repeat (12 * 30) @(negedge clk);
    cur_req = "R7";
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'd2; com_strobe = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; com_strobe = 1'b0;
    repeat (24 * 10) @(negedge clk);
    running = 1'b0;
    finish_run();
  end
endmodule